// File: doc/BRIEF.md
# Double-Banked Receive Endpoint Buffer

This block holds incoming bulk OUT packets for one endpoint in two 64-byte banks. The USB-side logic writes one byte per strobe and closes each packet with an end-of-packet strobe. The CPU drains the other bank through a byte read port. Filling and draining therefore overlap, and a second packet can land while the first one is still being read.

The CPU sees a receive-size register. It shows the byte count of the bank currently selected for reading, and a data-available flag shows that this bank holds a finished packet. When the CPU has taken what it needs, it pulses a read-finish trigger. The trigger returns the drained bank to the USB side, moves the read selection to the other bank and reloads the size register.

When both banks are full, the USB side sees not-ready and must NAK. A clear input empties the whole buffer after a cable disconnect. The clear is refused while a packet is half written or a bank is half read. Over-long packets and reads past the valid count each raise a flag.

Top module: `rxpp_buffer`

## Requirements
- R1: After reset, usb_ready is 1, data_avail is 0, rx_size is 0, and overflow and overread are both 0.
- R2: A packet of N bytes becomes visible one cycle after its end-of-packet strobe: data_avail=1 and rx_size=N. Each cpu_rd_en pulse returns the next byte in arrival order on cpu_rd_data one cycle later.
- R3: A second packet completing into the other bank does not change rx_size or the bytes being read until a trigger is given.
- R4: When both banks hold packets, usb_ready is 0. Byte writes and end-of-packet strobes offered in that state are dropped and create no packet.
- R5: A rd_done pulse while data_avail=1 frees the read bank (usb_ready returns to 1) and selects the other bank. rx_size then shows the other bank's count, or 0 if that bank is empty. Later reads return that bank's bytes.
- R6: A rd_done pulse while data_avail=0 does nothing. The next packet received is the one presented for reading.
- R7: A cpu_rd_en once the read position has reached rx_size sets overread to 1 and does not advance the read position. The returned byte has no defined value. A successful trigger clears overread.
- R8: A packet longer than 64 bytes keeps its first 64 bytes and reports rx_size=64. It sets overflow, which stays at 1 until an accepted clear.
- R9: A clear accepted while no transfer is in progress empties both banks: data_avail=0, rx_size=0, usb_ready=1, and both flags return to 0.
- R10: A clear is ignored while a packet has been started but not ended, while a bank has been partly read (read position between 0 and rx_size), or in a cycle that carries a write, end-of-packet or read strobe.
- R11: An end-of-packet strobe with no bytes makes a zero-length packet: data_avail=1 and rx_size=0.
- R12: A packet of exactly 64 bytes is kept whole with rx_size=64 and does not set overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| usb_wr_en | input | 1 | USB-side byte write strobe |
| usb_wr_data | input | 8 | USB-side byte |
| usb_eop | input | 1 | End of packet; closes the bank being filled |
| usb_ready | output | 1 | Bank available for reception; 0 means NAK |
| cpu_rd_en | input | 1 | CPU byte read strobe |
| cpu_rd_data | output | 8 | Byte read, valid the cycle after cpu_rd_en |
| rx_size | output | 7 | Byte count of the bank selected for reading |
| rd_done | input | 1 | Read-finish trigger; releases and swaps banks |
| clear | input | 1 | Empty both banks (disconnect) |
| data_avail | output | 1 | Read bank holds a completed packet |
| overflow | output | 1 | Sticky: bytes beyond 64 were dropped |
| overread | output | 1 | A read went past rx_size |

## Verification
The bench fills both banks so that usb_ready drops, then offers a packet. A design that let that packet through would show an extra packet after the banks are released. It pulses the trigger on an empty buffer: a design that swapped anyway would hide the next packet behind the wrong bank. It sends a 64-byte packet, a 66-byte packet and a zero-length packet to catch off-by-one counts, a misplaced overflow flag and zero-length packets that get lost. It also asserts clear mid-packet and mid-read, then again when idle, so that both a clear that wipes live data and a clear that never empties show up.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
    localparam int NBANKS = 2;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 64;
endpackage

// File: rtl/rxpp_bank.sv
module rxpp_bank #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/rxpp_ctrl.sv
module rxpp_ctrl #(
    parameter int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int NB    = rxpp_pkg::NBANKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             usb_wr_en,
    input  logic             usb_eop,
    input  logic             cpu_rd_en,
    input  logic             rd_done,
    input  logic             clear,
    output logic             usb_ready,
    output logic             data_avail,
    output logic [CNT_W-1:0] rx_size,
    output logic             overflow,
    output logic             overread,
    output logic [NB-1:0]    bank_we,
    output logic [NB-1:0]    bank_re,
    output logic [AW-1:0]    wr_addr,
    output logic [AW-1:0]    rd_addr,
    output logic             rd_sel
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        logic                        wr_bank;
        logic                        rd_bank;
        logic                        rd_sel;
        logic [NB-1:0]               full;
        logic [NB-1:0][CNT_W-1:0]    cnt;
        logic [CNT_W-1:0]            wr_ptr;
        logic [CNT_W-1:0]            rd_ptr;
        logic [CNT_W-1:0]            rx_size;
        logic                        ovf;
        logic                        ovr;
    } st_t;

    st_t  st_d, st_q;
    logic wr_ok, store, eop_ok, rd_ok, swap, busy;

    always_comb begin
        st_d    = st_q;
        bank_we = '0;
        bank_re = '0;
        wr_ok   = usb_wr_en && !st_q.full[st_q.wr_bank];
        store   = wr_ok && (st_q.wr_ptr < DEPTH_C);
        eop_ok  = usb_eop && !st_q.full[st_q.wr_bank];
        rd_ok   = cpu_rd_en && st_q.full[st_q.rd_bank] && (st_q.rd_ptr < st_q.rx_size);
        swap    = rd_done && st_q.full[st_q.rd_bank];
        busy    = (st_q.wr_ptr != '0) || usb_wr_en || usb_eop || cpu_rd_en ||
                  ((st_q.rd_ptr != '0) && (st_q.rd_ptr < st_q.rx_size));

        // USB side: store bytes up to the bank depth, drop the rest
        if (wr_ok && !store) st_d.ovf = 1'b1;
        if (store) begin
            bank_we[st_q.wr_bank] = 1'b1;
            st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        end
        if (eop_ok) begin
            st_d.full[st_q.wr_bank] = 1'b1;
            st_d.cnt[st_q.wr_bank]  = st_d.wr_ptr;
            st_d.wr_ptr  = '0;
            st_d.wr_bank = ~st_q.wr_bank;
        end

        // CPU side: bounded reads
        if (rd_ok) begin
            bank_re[st_q.rd_bank] = 1'b1;
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
            st_d.rd_sel = st_q.rd_bank;
        end else if (cpu_rd_en) begin
            st_d.ovr = 1'b1;
        end

        // Read-finish trigger: release bank, swap selection
        if (swap) begin
            st_d.full[st_q.rd_bank] = 1'b0;
            st_d.rd_bank = ~st_q.rd_bank;
            st_d.rd_ptr  = '0;
            st_d.ovr     = 1'b0;
        end

        if (clear && !busy) st_d = '0;

        st_d.rx_size = st_d.full[st_d.rd_bank] ? st_d.cnt[st_d.rd_bank] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign usb_ready  = !st_q.full[st_q.wr_bank];
    assign data_avail = st_q.full[st_q.rd_bank];
    assign rx_size    = st_q.rx_size;
    assign overflow   = st_q.ovf;
    assign overread   = st_q.ovr;
    assign wr_addr    = st_q.wr_ptr[AW-1:0];
    assign rd_addr    = st_q.rd_ptr[AW-1:0];
    assign rd_sel     = st_q.rd_sel;

    // R2, R12: the count shown never exceeds the bank depth, the read position never passes it
    assert_size_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rx_size <= DEPTH_C) && (st_q.rd_ptr <= st_q.rx_size));

    // R4: not-ready without a release or clear keeps both banks occupied
    assert_hold_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!usb_ready && !rd_done && !clear) |=> (st_q.full == '1));

    // R5: a trigger on a valid bank moves the read selection
    assert_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && data_avail) |=> (st_q.rd_bank != $past(st_q.rd_bank)));

    // R6: a trigger with nothing valid leaves the selection alone; empty buffer keeps pointers aligned
    assert_idle_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !data_avail) |=> (st_q.rd_bank == $past(st_q.rd_bank)));
    assert_empty_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full == '0) |-> (st_q.wr_bank == st_q.rd_bank));

    // R8: a byte offered past the depth raises overflow
    assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_wr_en && usb_ready && (st_q.wr_ptr == DEPTH_C)) |=> overflow);

    // R10: clear during a started packet does not discard it
    assert_clear_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && (st_q.wr_ptr != '0) && !usb_eop) |=> (st_q.wr_ptr != '0));
endmodule

// File: rtl/rxpp_buffer.sv
module rxpp_buffer #(
    parameter int DATA_W = rxpp_pkg::DATA_W,
    parameter int DEPTH  = rxpp_pkg::DEPTH,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int NB    = rxpp_pkg::NBANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_wr_en,
    input  logic [DATA_W-1:0] usb_wr_data,
    input  logic              usb_eop,
    output logic              usb_ready,
    input  logic              cpu_rd_en,
    output logic [DATA_W-1:0] cpu_rd_data,
    output logic [CNT_W-1:0]  rx_size,
    input  logic              rd_done,
    input  logic              clear,
    output logic              data_avail,
    output logic              overflow,
    output logic              overread
);
    logic [NB-1:0]     bank_we, bank_re;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic              rd_sel;
    logic [DATA_W-1:0] bank_rdata [NB];

    rxpp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .usb_wr_en(usb_wr_en), .usb_eop(usb_eop),
        .cpu_rd_en(cpu_rd_en), .rd_done(rd_done), .clear(clear),
        .usb_ready(usb_ready), .data_avail(data_avail), .rx_size(rx_size),
        .overflow(overflow), .overread(overread),
        .bank_we(bank_we), .bank_re(bank_re),
        .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_sel(rd_sel)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        rxpp_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
            .clk(clk),
            .we(bank_we[b]), .waddr(wr_addr), .wdata(usb_wr_data),
            .re(bank_re[b]), .raddr(rd_addr), .rdata(bank_rdata[b])
        );
    end

    assign cpu_rd_data = bank_rdata[rd_sel];
endmodule

// File: tb/rxpp_buffer_tb.sv
module rxpp_buffer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       usb_wr_en = 1'b0, usb_eop = 1'b0, cpu_rd_en = 1'b0;
    logic       rd_done = 1'b0, clear = 1'b0;
    logic [7:0] usb_wr_data = '0;
    logic       usb_ready, data_avail, overflow, overread;
    logic [7:0] cpu_rd_data;
    logic [6:0] rx_size;

    int    checks = 0, errors = 0;
    bit    done = 0;
    logic  rd_chk = 1'b0, chk_seen = 1'b0;
    logic [7:0] model [2][64];
    logic [7:0] exp_q [$];
    string cur_req = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    rxpp_buffer u_dut (
        .clk(clk), .rst_n(rst_n),
        .usb_wr_en(usb_wr_en), .usb_wr_data(usb_wr_data), .usb_eop(usb_eop),
        .usb_ready(usb_ready), .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
        .rx_size(rx_size), .rd_done(rd_done), .clear(clear),
        .data_avail(data_avail), .overflow(overflow), .overread(overread)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compares each completed read against the scoreboard queue
    always @(posedge clk) chk_seen <= cpu_rd_en && rd_chk;
    always @(negedge clk) begin
        if (chk_seen) begin
            if (exp_q.size() == 0) chk(cur_req, "unexpected read", 1, 0);
            else chk(cur_req, "read byte", int'(cpu_rd_data), int'(exp_q.pop_front()));
        end
    end

    // Driver: bytes then optional end-of-packet; bank<0 means not recorded
    task automatic send_pkt(int n, logic [7:0] seed, bit eop, int bank);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            usb_wr_en = 1'b1;
            usb_wr_data = 8'(seed + i);
            if (bank >= 0 && i < 64) model[bank][i] = 8'(seed + i);
        end
        @(negedge clk);
        usb_wr_en = 1'b0;
        if (eop) begin
            usb_eop = 1'b1;
            @(negedge clk);
            usb_eop = 1'b0;
        end
    endtask

    task automatic read_bytes(int bank, int first, int n, string req);
        cur_req = req;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cpu_rd_en = 1'b1;
            rd_chk = 1'b1;
            exp_q.push_back(model[bank][first + i]);
        end
        @(negedge clk);
        cpu_rd_en = 1'b0;
        rd_chk = 1'b0;
        @(negedge clk);
    endtask

    task automatic bad_read();
        @(negedge clk); cpu_rd_en = 1'b1;
        @(negedge clk); cpu_rd_en = 1'b0;
    endtask

    task automatic trigger();
        @(negedge clk); rd_done = 1'b1;
        @(negedge clk); rd_done = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "usb_ready", usb_ready, 1);
        chk("R1", "data_avail", data_avail, 0);
        chk("R1", "rx_size", rx_size, 0);
        chk("R1", "overflow", overflow, 0);
        chk("R1", "overread", overread, 0);

        // R2 first packet into bank 0
        send_pkt(5, 8'h10, 1, 0);
        chk("R2", "data_avail", data_avail, 1);
        chk("R2", "rx_size", rx_size, 5);

        // R12 exact 64-byte packet into bank 1; R3 size unchanged; R4 both full
        send_pkt(64, 8'h40, 1, 1);
        chk("R12", "overflow", overflow, 0);
        chk("R3", "rx_size held", rx_size, 5);
        chk("R4", "usb_ready when full", usb_ready, 0);
        read_bytes(0, 0, 5, "R2");
        send_pkt(3, 8'hA0, 1, -1);    // offered while not ready: dropped
        chk("R4", "still not ready", usb_ready, 0);

        // R5 swap to bank 1
        trigger();
        chk("R5", "rx_size", rx_size, 64);
        chk("R5", "usb_ready freed", usb_ready, 1);
        chk("R5", "data_avail", data_avail, 1);
        read_bytes(1, 0, 64, "R12");

        // R7 overread
        bad_read();
        chk("R7", "overread", overread, 1);
        trigger();
        chk("R7", "overread cleared", overread, 0);
        chk("R4", "dropped packet absent", data_avail, 0);
        chk("R5", "rx_size empty", rx_size, 0);

        // R6 trigger with nothing valid
        trigger();
        chk("R6", "data_avail", data_avail, 0);
        send_pkt(3, 8'h70, 1, 0);
        chk("R6", "next packet visible", data_avail, 1);
        chk("R6", "rx_size", rx_size, 3);
        read_bytes(0, 0, 3, "R6");
        trigger();

        // R8 over-long packet into bank 1
        send_pkt(66, 8'h01, 1, 1);
        chk("R8", "rx_size", rx_size, 64);
        chk("R8", "overflow", overflow, 1);
        read_bytes(1, 0, 64, "R8");
        trigger();
        chk("R8", "overflow sticky", overflow, 1);

        // R11 zero-length packet into bank 0
        @(negedge clk); usb_eop = 1'b1;
        @(negedge clk); usb_eop = 1'b0;
        chk("R11", "data_avail", data_avail, 1);
        chk("R11", "rx_size", rx_size, 0);
        bad_read();
        chk("R7", "overread on empty packet", overread, 1);
        trigger();

        // R10 clear ignored mid-packet and mid-read (bank 1)
        send_pkt(4, 8'hC0, 0, 1);
        do_clear();
        @(negedge clk); usb_eop = 1'b1;
        @(negedge clk); usb_eop = 1'b0;
        chk("R10", "packet survived clear", rx_size, 4);
        read_bytes(1, 0, 2, "R10");
        do_clear();
        chk("R10", "data_avail after mid-read clear", data_avail, 1);
        chk("R10", "overflow kept", overflow, 1);
        read_bytes(1, 2, 2, "R10");

        // R9 clear with both banks full
        send_pkt(2, 8'hE0, 1, 0);
        chk("R9", "both full", usb_ready, 0);
        do_clear();
        chk("R9", "data_avail", data_avail, 0);
        chk("R9", "rx_size", rx_size, 0);
        chk("R9", "usb_ready", usb_ready, 1);
        chk("R9", "overflow", overflow, 0);
        trigger();
        chk("R9", "still empty", data_avail, 0);
        chk("R2", "scoreboard drained", exp_q.size(), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule